// File: doc/BRIEF.md
# Prefetch and Write-Posting Engine

This block moves a programmed number of bytes between a host and a byte-wide external memory port on behalf of one chip select. In read mode it fetches bytes from the device ahead of the consumer and holds them in an internal FIFO. In write mode it accepts bytes that the host posts into the FIFO and drains them to the device. A 32-bit register interface carries four registers: a configuration word, a byte count, a run/stop control and a status word. The status word shows the FIFO fill level and the number of bytes still to move.

A threshold request tells the host or a DMA channel when to service the FIFO. In read mode it asserts when enough bytes are waiting. In write mode it asserts when enough space is free. When the transfer completes, the engine clears its own run bit and pulses a completion interrupt. That interrupt is attributed to the chip select held in the configuration word.

Top module: `pfe_engine`

Register map by `reg_addr`: 0 is configuration, 1 is byte count, 2 is control, 3 is status (read-only).

## Requirements
- R1: After reset the control, configuration and count registers read 0, the status fill is 0, and `dev_req`, `cpu_req`, `dma_req` and `done_irq` are all low.
- R2: Configuration word field layout:
  - bit 0 is direction (0 = read, 1 = write);
  - bit 2 selects DMA (1) or host CPU (0);
  - bit 7 is enable;
  - bits 14:8 are the threshold;
  - bits 26:24 are the chip select.
  The word reads back with these fields. The chip select appears on `dev_cs` and `irq_cs`.
- R3: A threshold above the FIFO depth (64) is stored as 64, and status bit 7 is set. A legal threshold clears status bit 7.
- R4: Writes to the configuration and count registers are ignored while the run bit is 1. They are accepted while it is 0, including a write of zero to the configuration.
- R5: Writing 1 to control bit 0 sets the run bit and empties the FIFO, but only when the run bit is 0 and enable is set. Otherwise the write has no effect.
- R6: Writing 0 to control bit 0 clears the run bit at the next edge, empties the FIFO and drops `dev_req`.
- R7: In read mode `dev_req` is high while running, with bytes remaining and the FIFO not full. Each `dev_ack` accepted with `dev_req` stores `dev_rdata` in the FIFO and decrements the remaining count. `host_pop` returns the bytes in arrival order on `host_rdata`, even after the run bit clears.
- R8: In write mode `host_push` is accepted only while running, with the FIFO not full and its fill below the remaining count; further pushes are dropped. `dev_req` is high while the FIFO is not empty, with `dev_we` = 1 and `dev_wdata` giving the oldest byte. Each accepted `dev_ack` removes that byte and decrements the remaining count.
- R9: While running, the threshold request asserts as follows:
  - in read mode, when fill ≥ threshold;
  - in write mode, when (64 − fill) ≥ threshold.

  It appears on `dma_req` when the DMA bit is 1 and on `cpu_req` otherwise, never on both, and is low when not running.
- R10: Once the remaining count is zero while running (in write mode with the FIFO empty), the next edge clears the run bit and raises `done_irq` for exactly one cycle. This includes a start with a count of zero.
- R11: Status word layout: bits 6:0 hold the FIFO fill, bit 7 the threshold error, bit 8 the run bit, and bits 29:16 the remaining byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| host_push | input | 1 | Host posts a byte (write mode) |
| host_wdata | input | 8 | Posted byte |
| host_pop | input | 1 | Host takes a byte (read mode) |
| host_rdata | output | 8 | Oldest FIFO byte |
| dev_req | output | 1 | Device transfer request |
| dev_we | output | 1 | Device direction, 1 = write |
| dev_cs | output | 3 | Chip select of the transfer |
| dev_wdata | output | 8 | Byte to the device |
| dev_rdata | input | 8 | Byte from the device |
| dev_ack | input | 1 | Device completes one byte |
| cpu_req | output | 1 | Threshold request, host CPU mode |
| dma_req | output | 1 | Threshold request, DMA mode |
| done_irq | output | 1 | One-cycle completion pulse |
| irq_cs | output | 3 | Chip select the interrupt belongs to |

## Verification
A register write or an accepted byte changes internal state at the clock edge that samples it. `reg_rdata`, `dev_req` and both threshold requests follow from that state with no further register, so they are correct one edge after the stimulus. `done_irq` goes high one edge after the remaining count reaches zero, and falls one edge later. The bench drives inputs and samples outputs at falling edges, so each check falls in the half-cycle where its result is due. The completion pulse is checked at both the cycle it is expected and the cycle after.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_CNT  = 2'd1,
    REG_CTL  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  localparam int THR_W   = 7;
  localparam int CS_W    = 3;
  localparam int CS_LSB  = 24;
  localparam int THR_LSB = 8;
  localparam int EN_BIT  = 7;
  localparam int DMA_BIT = 2;
  localparam int DIR_BIT = 0;

  typedef struct packed {
    logic [CS_W-1:0]  cs;
    logic [THR_W-1:0] thr;
    logic             en;
    logic             dma;
    logic             dir;
  } cfg_t;

  function automatic logic [31:0] cfg_pack(cfg_t c);
    logic [31:0] w;
    w = '0;
    w[CS_LSB +: CS_W]   = c.cs;
    w[THR_LSB +: THR_W] = c.thr;
    w[EN_BIT]           = c.en;
    w[DMA_BIT]          = c.dma;
    w[DIR_BIT]          = c.dir;
    return w;
  endfunction

endpackage

// File: rtl/pfe_fifo.sv
module pfe_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int FW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [FW-1:0] fill,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [FW-1:0] cnt_q, cnt_n;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == FW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_q];
  assign fill    = cnt_q;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (push_ok) wr_n = wr_q + AW'(1);
      if (pop_ok)  rd_n = rd_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_n = cnt_q + FW'(1);
        2'b01:   cnt_n = cnt_q - FW'(1);
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_q] <= din;
  end

endmodule

// File: rtl/pfe_cfg_regs.sv
module pfe_cfg_regs
  import pfe_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             dec,
  input  logic             finish,
  output cfg_t             cfg,
  output logic             thr_err,
  output logic [CNT_W-1:0] remaining,
  output logic             run,
  output logic             flush
);

  cfg_t             cfg_q, cfg_n;
  logic             err_q, err_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             run_q, run_n;
  logic [THR_W-1:0] wthr;
  logic             unused_wbits;

  assign wthr         = reg_wdata[THR_LSB +: THR_W];
  assign unused_wbits = ^{reg_wdata[31:CS_LSB+CS_W], reg_wdata[23:THR_LSB+THR_W],
                          reg_wdata[6:3], reg_wdata[1]};

  always_comb begin
    cfg_n = cfg_q;
    err_n = err_q;
    rem_n = rem_q;
    run_n = run_q;
    flush = 1'b0;
    if (dec)    rem_n = rem_q - CNT_W'(1);
    if (finish) run_n = 1'b0;
    if (reg_we) begin
      case (reg_addr)
        REG_CFG: if (!run_q) begin
          cfg_n.cs  = reg_wdata[CS_LSB +: CS_W];
          cfg_n.en  = reg_wdata[EN_BIT];
          cfg_n.dma = reg_wdata[DMA_BIT];
          cfg_n.dir = reg_wdata[DIR_BIT];
          if (wthr > THR_W'(DEPTH)) begin
            cfg_n.thr = THR_W'(DEPTH);
            err_n     = 1'b1;
          end else begin
            cfg_n.thr = wthr;
            err_n     = 1'b0;
          end
        end
        REG_CNT: if (!run_q) rem_n = reg_wdata[CNT_W-1:0];
        REG_CTL: begin
          if (!reg_wdata[0]) begin
            run_n = 1'b0;
            flush = 1'b1;
          end else if (!run_q && cfg_q.en) begin
            run_n = 1'b1;
            flush = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
      rem_q <= '0;
      run_q <= 1'b0;
    end else begin
      cfg_q <= cfg_n;
      err_q <= err_n;
      rem_q <= rem_n;
      run_q <= run_n;
    end
  end

  assign cfg       = cfg_q;
  assign thr_err   = err_q;
  assign remaining = rem_q;
  assign run       = run_q;

endmodule

// File: rtl/pfe_xfer.sv
module pfe_xfer #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  parameter int THR_W = 7,
  localparam int FW   = $clog2(DEPTH) + 1,
  localparam int CW   = (FW > THR_W) ? FW : THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             dir,
  input  logic             dma,
  input  logic [THR_W-1:0] thr,
  input  logic [CNT_W-1:0] remaining,
  input  logic [FW-1:0]    fill,
  input  logic             full,
  input  logic             empty,
  input  logic             host_push,
  input  logic             host_pop,
  input  logic             dev_ack,
  output logic             dev_req,
  output logic             fifo_push,
  output logic             fifo_pop,
  output logic             dec,
  output logic             finish,
  output logic             cpu_req,
  output logic             dma_req,
  output logic             done_irq
);

  logic          rem_nz, dev_xfer, hit, room_left;
  logic [CW-1:0] fill_x, free_x, thr_x;
  logic          done_q, done_n;

  assign rem_nz    = (remaining != '0);
  assign room_left = (CNT_W'(fill) < remaining);
  assign dev_req   = run && (dir ? !empty : (rem_nz && !full));
  assign dev_xfer  = dev_req && dev_ack;
  assign fifo_push = dir ? (run && host_push && !full && room_left) : dev_xfer;
  assign fifo_pop  = dir ? dev_xfer : (host_pop && !empty);
  assign dec       = dev_xfer;
  assign finish    = run && !rem_nz && (!dir || empty);

  assign fill_x = CW'(fill);
  assign free_x = CW'(DEPTH) - fill_x;
  assign thr_x  = CW'(thr);
  assign hit    = run && (dir ? (free_x >= thr_x) : (fill_x >= thr_x));
  assign cpu_req = hit && !dma;
  assign dma_req = hit && dma;

  assign done_n = finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign done_irq = done_q;

endmodule

// File: rtl/pfe_engine.sv
module pfe_engine
  import pfe_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        host_push,
  input  logic [7:0]  host_wdata,
  input  logic        host_pop,
  output logic [7:0]  host_rdata,
  output logic        dev_req,
  output logic        dev_we,
  output logic [2:0]  dev_cs,
  output logic [7:0]  dev_wdata,
  input  logic [7:0]  dev_rdata,
  input  logic        dev_ack,
  output logic        cpu_req,
  output logic        dma_req,
  output logic        done_irq,
  output logic [2:0]  irq_cs
);

  localparam int FW = $clog2(DEPTH) + 1;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  cfg_t             cfg;
  logic [31:0]      cfg_word;
  logic             thr_err, eng_run, flush, dec, finish;
  logic             cfg_dir;
  logic [CNT_W-1:0] eng_rem;
  logic [FW-1:0]    eng_fill;
  logic             full, empty, fifo_push, fifo_pop;
  logic [7:0]       fifo_din, fifo_dout;
  logic [31:0]      stat_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pfe_cfg_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dec       (dec),
    .finish    (finish),
    .cfg       (cfg),
    .thr_err   (thr_err),
    .remaining (eng_rem),
    .run       (eng_run),
    .flush     (flush)
  );

  assign cfg_dir  = cfg.dir;
  assign fifo_din = cfg_dir ? host_wdata : dev_rdata;

  pfe_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .flush (flush),
    .push  (fifo_push),
    .din   (fifo_din),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .fill  (eng_fill),
    .full  (full),
    .empty (empty)
  );

  pfe_xfer #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (eng_run),
    .dir       (cfg_dir),
    .dma       (cfg.dma),
    .thr       (cfg.thr),
    .remaining (eng_rem),
    .fill      (eng_fill),
    .full      (full),
    .empty     (empty),
    .host_push (host_push),
    .host_pop  (host_pop),
    .dev_ack   (dev_ack),
    .dev_req   (dev_req),
    .fifo_push (fifo_push),
    .fifo_pop  (fifo_pop),
    .dec       (dec),
    .finish    (finish),
    .cpu_req   (cpu_req),
    .dma_req   (dma_req),
    .done_irq  (done_irq)
  );

  assign cfg_word = cfg_pack(cfg);

  always_comb begin
    stat_word               = '0;
    stat_word[FW-1:0]       = eng_fill;
    stat_word[7]            = thr_err;
    stat_word[8]            = eng_run;
    stat_word[16 +: CNT_W]  = eng_rem;
  end

  always_comb begin
    case (reg_addr)
      REG_CFG:  reg_rdata = cfg_word;
      REG_CNT:  reg_rdata = 32'(eng_rem);
      REG_CTL:  reg_rdata = {31'b0, eng_run};
      default:  reg_rdata = stat_word;
    endcase
  end

  assign host_rdata = fifo_dout;
  assign dev_wdata  = fifo_dout;
  assign dev_we     = cfg_dir;
  assign dev_cs     = cfg.cs;
  assign irq_cs     = cfg.cs;

endmodule

// File: rtl/pfe_engine_chk.sv
module pfe_engine_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  localparam int FW   = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic             ctl_bit,
  input logic             run,
  input logic             dir,
  input logic [FW-1:0]    fill,
  input logic [CNT_W-1:0] remaining,
  input logic [31:0]      cfg_word,
  input logic             done_irq,
  input logic             cpu_req,
  input logic             dma_req,
  input logic             dev_req
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R10
  done_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !run);

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  // R8
  post_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dir) |-> (CNT_W'(fill) <= remaining));

  // R9
  req_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req && dma_req));

  // R4
  busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && reg_we && reg_addr == pfe_pkg::REG_CFG) |=> $stable(cfg_word));

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == pfe_pkg::REG_CTL && !ctl_bit) |=> !run);

  // R1
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> run);

endmodule

bind pfe_engine pfe_engine_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .ctl_bit   (reg_wdata[0]),
  .run       (eng_run),
  .dir       (cfg_dir),
  .fill      (eng_fill),
  .remaining (eng_rem),
  .cfg_word  (cfg_word),
  .done_irq  (done_irq),
  .cpu_req   (cpu_req),
  .dma_req   (dma_req),
  .dev_req   (dev_req)
);

// File: tb/pfe_engine_bench.sv
module pfe_engine_bench;

  logic        clk, rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        host_push, host_pop;
  logic [7:0]  host_wdata, host_rdata;
  logic        dev_req, dev_we, dev_ack, cpu_req, dma_req, done_irq;
  logic [2:0]  dev_cs, irq_cs;
  logic [7:0]  dev_wdata, dev_rdata;

  int checks = 0;
  int fails  = 0;

  pfe_engine u_pfe_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_push(host_push),
    .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
    .dev_req(dev_req), .dev_we(dev_we), .dev_cs(dev_cs), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .dev_ack(dev_ack), .cpu_req(cpu_req),
    .dma_req(dma_req), .done_irq(done_irq), .irq_cs(irq_cs)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_cfg(input int cs, input int thr, input bit en,
                                         input bit dma, input bit dir);
    return (32'(cs) << 24) | (32'(thr) << 8) | (32'(en) << 7) | (32'(dma) << 2) | 32'(dir);
  endfunction

  task automatic ack_read(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      dev_ack = 1'b1; dev_rdata = base + 8'(i);
      @(negedge clk);
    end
    dev_ack = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd_reg(2'd0, v); chk("R1 cfg", v, 0);
    rd_reg(2'd1, v); chk("R1 cnt", v, 0);
    rd_reg(2'd2, v); chk("R1 ctl", v, 0);
    rd_reg(2'd3, v); chk("R1 stat", v, 0);
    chk("R1 outs", {dev_req, cpu_req, dma_req, done_irq}, 0);
  endtask

  task automatic t_config;
    logic [31:0] v;
    wr_reg(2'd0, mk_cfg(5, 16, 1, 0, 0));
    rd_reg(2'd0, v); chk("R2 readback", v, mk_cfg(5, 16, 1, 0, 0));
    chk("R2 cs pins", {dev_cs, irq_cs}, {3'd5, 3'd5});
    wr_reg(2'd0, mk_cfg(5, 100, 1, 0, 0));
    rd_reg(2'd0, v); chk("R3 clamp", v, mk_cfg(5, 64, 1, 0, 0));
    rd_reg(2'd3, v); chk("R3 err set", v[7], 1);
    wr_reg(2'd0, mk_cfg(5, 64, 1, 0, 0));
    rd_reg(2'd3, v); chk("R3 err clear", v[7], 0);
  endtask

  task automatic t_read;
    logic [31:0] v;
    wr_reg(2'd0, mk_cfg(3, 4, 1, 0, 0));
    wr_reg(2'd1, 32'd10);
    wr_reg(2'd2, 32'd1);
    rd_reg(2'd2, v); chk("R5 started", v, 1);
    chk("R7 req", dev_req, 1);
    chk("R9 below", cpu_req, 0);
    ack_read(3, 8'hA0);
    chk("R9 fill3", cpu_req, 0);
    ack_read(1, 8'hA3);
    chk("R9 fill4", cpu_req, 1);
    chk("R9 no dma", dma_req, 0);
    rd_reg(2'd3, v);
    chk("R11 stat", v, (32'd6 << 16) | (32'd1 << 8) | 32'd4);
    ack_read(6, 8'hA4);
    chk("R7 req off", dev_req, 0);
    chk("R10 not yet", done_irq, 0);
    rd_reg(2'd2, v); chk("R10 still run", v, 1);
    @(negedge clk);
    chk("R10 pulse", done_irq, 1);
    rd_reg(2'd2, v); chk("R10 ctl clear", v, 0);
    chk("R9 idle", cpu_req, 0);
    @(negedge clk);
    chk("R10 pulse end", done_irq, 0);
    for (int i = 0; i < 10; i++) begin
      chk("R7 order", host_rdata, 8'hA0 + 8'(i));
      host_pop = 1'b1;
      @(negedge clk);
      host_pop = 1'b0;
    end
    rd_reg(2'd3, v); chk("R7 drained", v[6:0], 0);
  endtask

  task automatic t_busy_stop;
    logic [31:0] v;
    wr_reg(2'd0, mk_cfg(2, 8, 1, 0, 0));
    wr_reg(2'd1, 32'd20);
    wr_reg(2'd2, 32'd1);
    ack_read(2, 8'h10);
    wr_reg(2'd0, 32'd0);
    rd_reg(2'd0, v); chk("R4 cfg held", v, mk_cfg(2, 8, 1, 0, 0));
    wr_reg(2'd1, 32'd5);
    rd_reg(2'd1, v); chk("R4 cnt held", v, 18);
    wr_reg(2'd2, 32'd1);
    rd_reg(2'd3, v); chk("R5 restart ignored", v[8:0], 9'h102);
    wr_reg(2'd2, 32'd0);
    rd_reg(2'd2, v); chk("R6 stopped", v, 0);
    rd_reg(2'd3, v); chk("R6 flushed", v[6:0], 0);
    chk("R6 req drop", dev_req, 0);
    wr_reg(2'd0, 32'd0);
    rd_reg(2'd0, v); chk("R4 cfg cleared", v, 0);
    wr_reg(2'd1, 32'd3);
    wr_reg(2'd2, 32'd1);
    rd_reg(2'd2, v); chk("R5 no enable", v, 0);
    chk("R5 no req", dev_req, 0);
  endtask

  task automatic t_write;
    logic [31:0] v;
    wr_reg(2'd0, mk_cfg(6, 60, 1, 1, 1));
    wr_reg(2'd1, 32'd5);
    wr_reg(2'd2, 32'd1);
    chk("R9 dma free", {dma_req, cpu_req}, 2'b10);
    chk("R8 empty", dev_req, 0);
    chk("R2 irq cs", irq_cs, 6);
    for (int i = 0; i < 7; i++) begin
      host_push = 1'b1; host_wdata = 8'h50 + 8'(i);
      @(negedge clk);
    end
    host_push = 1'b0;
    rd_reg(2'd3, v); chk("R8 push limit", v[6:0], 5);
    chk("R9 dma space", dma_req, 0);
    for (int i = 0; i < 5; i++) begin
      chk("R8 req", {dev_req, dev_we}, 2'b11);
      chk("R8 data", dev_wdata, 8'h50 + 8'(i));
      dev_ack = 1'b1;
      @(negedge clk);
    end
    dev_ack = 1'b0;
    rd_reg(2'd3, v); chk("R8 count zero", v[29:16], 0);
    @(negedge clk);
    chk("R10 write pulse", done_irq, 1);
    rd_reg(2'd2, v); chk("R10 write ctl", v, 0);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    wr_reg(2'd0, mk_cfg(1, 1, 1, 0, 0));
    wr_reg(2'd1, 32'd0);
    wr_reg(2'd2, 32'd1);
    chk("R10 zero not yet", done_irq, 0);
    @(negedge clk);
    chk("R10 zero pulse", done_irq, 1);
    rd_reg(2'd2, v); chk("R10 zero ctl", v, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    host_push = 1'b0; host_pop = 1'b0; host_wdata = '0;
    dev_ack = 1'b0; dev_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_config;
    t_read;
    t_busy_stop;
    t_write;
    t_zero;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule